// File: doc/BRIEF.md
# DSD-over-PCM stream detector

This block sits on a stereo stream of 24-bit carrier samples and decides, frame by frame, whether the stream is carrying one-bit DSD audio packed into PCM words. A packed frame has a marker byte in the top eight bits of each channel word and sixteen consecutive one-bit samples in the low sixteen bits. Once a long enough unbroken run of correctly marked frames has been seen, the block switches its output path to DSD. From then on it emits the 16-bit payload of each channel with its own valid strobe. The first frame that fails the marker check drops the block back to PCM, and samples then pass through untouched.

The marker scheme does not depend on rate. A 176.4 kHz carrier gives single-rate DSD and a 352.8 kHz carrier gives double-rate DSD, and the block behaves the same for both. Samples are checked exactly as received, so any gain or processing upstream will defeat detection. An enable input turns detection off entirely. The run length needed to lock is set on a port.

A three-state machine controls the mode. `ST_OFF` means detection is disabled. `ST_SEEK` means PCM output while consecutive good frames are counted. `ST_LOCK` means DSD output. The transitions are:
- `ST_OFF` to `ST_SEEK` when enable is high.
- `ST_SEEK` to `ST_LOCK` on a good frame that arrives while the run count already stands at the threshold.
- `ST_LOCK` to `ST_SEEK` on any accepted frame that is not good.
- Any state to `ST_OFF` while enable is low.

Top module: `dop_detect`

## Requirements
- R1: After synchronous reset, `mode_dsd`, `pcm_valid` and `dsd_valid` are all 0.
- R2: A frame is well-formed when the top byte (bits 23:16) of both channels holds the same value and that value is 0x05 or 0xFA. A frame is good when it is well-formed and its marker is the bitwise complement of the previous well-formed frame's marker. The first well-formed frame after reset, after a malformed frame or after disable is always good.
- R3: DSD mode is entered on the good frame that makes the run of consecutive good frames longer than `run_threshold`. That frame is still output as PCM. `mode_dsd` rises together with its output, one cycle after it is accepted, and the following good frames are output as DSD.
- R4: The run count saturates at `run_threshold`, so runs of any length, with any threshold up to the port maximum (255 by default), lock and stay locked.
- R5: In DSD mode, an accepted frame that is not good is output as PCM, and `mode_dsd` falls together with that output.
- R6: A frame that is well-formed but breaks the alternation restarts the run at length 1. A malformed frame restarts it at length 0 and clears the expected marker.
- R7: While `det_enable` is low, `mode_dsd` is 0 from the next cycle on, every frame is output as PCM and the run is cleared. After re-enable, a full run is needed again.
- R8: A frame output as PCM appears one cycle after acceptance as the unchanged 24-bit `pcm_left`/`pcm_right` with `pcm_valid`=1 and `dsd_valid`=0.
- R9: A frame output as DSD appears one cycle after acceptance as bits 15:0 of each channel on `dsd_left`/`dsd_right`, with bit 15 the earliest one-bit sample, `dsd_valid`=1 and `pcm_valid`=0.
- R10: Cycles with `in_valid` low neither advance nor break the run, and both output valids are 0 in the cycle after them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| det_enable | input | 1 | Detection enable |
| run_threshold | input | 8 | Good frames the run must exceed before DSD mode |
| in_valid | input | 1 | A stereo frame is presented |
| in_left | input | 24 | Left carrier sample |
| in_right | input | 24 | Right carrier sample |
| mode_dsd | output | 1 | 1 while locked to DSD |
| pcm_valid | output | 1 | PCM frame on pcm_left/pcm_right |
| pcm_left | output | 24 | Left PCM sample |
| pcm_right | output | 24 | Right PCM sample |
| dsd_valid | output | 1 | DSD payload on dsd_left/dsd_right |
| dsd_left | output | 16 | Left payload, bit 15 earliest |
| dsd_right | output | 16 | Right payload, bit 15 earliest |

## Verification
The bench targets the frame that completes the run. A design that let this frame through as DSD, or counted the run one frame short, would show the payload one frame early. A repeated marker while locked must restart the run at one rather than zero, and a design that got this wrong would relock a frame late or early. Frames whose two channels carry different markers must be rejected; a design that checked only the left channel would stay locked through them. A threshold of 0 and a threshold of 255 with a 300-frame run check the saturating count: a wrapping or off-by-one counter would miss the lock or lock on the wrong frame. Disabling while locked and then re-enabling must demand a fresh full run, so a design that kept its count would relock at once.

// File: rtl/dop_pkg.sv
package dop_pkg;
    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_SEEK = 2'd1,
        ST_LOCK = 2'd2
    } dop_state_t;

    localparam int unsigned MARK_W = 8;
    localparam logic [MARK_W-1:0] MARK_A = 8'h05;
    localparam logic [MARK_W-1:0] MARK_B = 8'hFA;
endpackage

// File: rtl/dop_marker_check.sv
module dop_marker_check
    import dop_pkg::*;
#(
    parameter int unsigned SAMPLE_W = 24
) (
    input  logic [SAMPLE_W-1:0] left_s,
    input  logic [SAMPLE_W-1:0] right_s,
    input  logic                have_exp,
    input  logic [MARK_W-1:0]   exp_mark,
    output logic                well,
    output logic                seq_ok,
    output logic [MARK_W-1:0]   mark_seen
);
    logic [MARK_W-1:0] mark_l;
    logic [MARK_W-1:0] mark_r;

    assign mark_l = left_s[SAMPLE_W-1 -: MARK_W];
    assign mark_r = right_s[SAMPLE_W-1 -: MARK_W];

    always_comb begin
        mark_seen = mark_l;
        well      = (mark_l == mark_r) && ((mark_l == MARK_A) || (mark_l == MARK_B));
        seq_ok    = well && (!have_exp || (mark_l == exp_mark));
    end
endmodule

// File: rtl/dop_run_tracker.sv
module dop_run_tracker
    import dop_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              frame_v,
    input  logic              well,
    input  logic              seq_ok,
    input  logic [MARK_W-1:0] mark_seen,
    input  logic [CNT_W-1:0]  thr,
    output logic              have_exp,
    output logic [MARK_W-1:0] exp_mark,
    output logic              at_thr
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q    <= '0;
            have_exp <= 1'b0;
            exp_mark <= '0;
        end else if (frame_v) begin
            if (seq_ok) begin
                cnt_q <= (cnt_q >= thr) ? thr : cnt_q + CNT_W'(1);
            end else if (well) begin
                cnt_q <= (thr == '0) ? '0 : CNT_W'(1);
            end else begin
                cnt_q <= '0;
            end
            have_exp <= well;
            exp_mark <= ~mark_seen;
        end
    end

    assign at_thr = (cnt_q >= thr);

    // R4: a good frame at the threshold leaves the count pinned there
    a_r4_saturate: assert property (@(posedge clk) disable iff (rst)
        (!clear && frame_v && seq_ok && at_thr) |=> (cnt_q == $past(thr)));

    // R6: a malformed frame drops the expected marker
    a_r6_malformed_clears: assert property (@(posedge clk) disable iff (rst)
        (frame_v && !well) |=> !have_exp);
endmodule

// File: rtl/dop_mode_fsm.sv
module dop_mode_fsm
    import dop_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       enable,
    input  logic       frame_v,
    input  logic       seq_ok,
    input  logic       at_thr,
    output dop_state_t state_q,
    output logic       tracker_clear,
    output logic       emit_dsd
);
    dop_state_t state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:  if (enable) state_d = ST_SEEK;
            ST_SEEK: begin
                if (!enable)                          state_d = ST_OFF;
                else if (frame_v && seq_ok && at_thr) state_d = ST_LOCK;
            end
            ST_LOCK: begin
                if (!enable)                state_d = ST_OFF;
                else if (frame_v && !seq_ok) state_d = ST_SEEK;
            end
            default: state_d = ST_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_OFF;
        else     state_q <= state_d;
    end

    always_comb begin
        tracker_clear = (state_q == ST_OFF) || !enable;
        emit_dsd      = (state_q == ST_LOCK) && enable && frame_v && seq_ok;
    end

    // R3: lock is only reached through a good frame at the threshold
    a_r3_entry: assert property (@(posedge clk) disable iff (rst)
        $rose(state_q == ST_LOCK) |-> $past(frame_v && seq_ok && at_thr));

    // R5: a failing frame while locked leaves lock at once
    a_r5_drop: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_LOCK && enable && frame_v && !seq_ok) |=> (state_q == ST_SEEK));

    // R7: disabled means off on the next cycle
    a_r7_off: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (state_q == ST_OFF));
endmodule

// File: rtl/dop_detect.sv
module dop_detect
    import dop_pkg::*;
#(
    parameter int unsigned SAMPLE_W  = 24,
    parameter int unsigned PAYLOAD_W = 16,
    parameter int unsigned CNT_W     = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 det_enable,
    input  logic [CNT_W-1:0]     run_threshold,
    input  logic                 in_valid,
    input  logic [SAMPLE_W-1:0]  in_left,
    input  logic [SAMPLE_W-1:0]  in_right,
    output logic                 mode_dsd,
    output logic                 pcm_valid,
    output logic [SAMPLE_W-1:0]  pcm_left,
    output logic [SAMPLE_W-1:0]  pcm_right,
    output logic                 dsd_valid,
    output logic [PAYLOAD_W-1:0] dsd_left,
    output logic [PAYLOAD_W-1:0] dsd_right
);
    logic              well;
    logic              seq_ok;
    logic [MARK_W-1:0] mark_seen;
    logic              have_exp;
    logic [MARK_W-1:0] exp_mark;
    logic              at_thr;
    logic              tracker_clear;
    logic              emit_dsd;
    dop_state_t        state_q;

    dop_marker_check #(.SAMPLE_W(SAMPLE_W)) u_check (
        .left_s(in_left), .right_s(in_right),
        .have_exp(have_exp), .exp_mark(exp_mark),
        .well(well), .seq_ok(seq_ok), .mark_seen(mark_seen)
    );

    dop_run_tracker #(.CNT_W(CNT_W)) u_track (
        .clk(clk), .rst(rst), .clear(tracker_clear),
        .frame_v(in_valid), .well(well), .seq_ok(seq_ok),
        .mark_seen(mark_seen), .thr(run_threshold),
        .have_exp(have_exp), .exp_mark(exp_mark), .at_thr(at_thr)
    );

    dop_mode_fsm u_fsm (
        .clk(clk), .rst(rst), .enable(det_enable),
        .frame_v(in_valid), .seq_ok(seq_ok), .at_thr(at_thr),
        .state_q(state_q), .tracker_clear(tracker_clear), .emit_dsd(emit_dsd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pcm_valid <= 1'b0;
            dsd_valid <= 1'b0;
            pcm_left  <= '0;
            pcm_right <= '0;
            dsd_left  <= '0;
            dsd_right <= '0;
        end else begin
            pcm_valid <= in_valid && !emit_dsd;
            dsd_valid <= emit_dsd;
            if (in_valid) begin
                if (emit_dsd) begin
                    dsd_left  <= in_left[PAYLOAD_W-1:0];
                    dsd_right <= in_right[PAYLOAD_W-1:0];
                end else begin
                    pcm_left  <= in_left;
                    pcm_right <= in_right;
                end
            end
        end
    end

    assign mode_dsd = (state_q == ST_LOCK);

    // R9: payload strobes never coincide with PCM strobes
    a_r9_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(pcm_valid && dsd_valid));

    // R9: payload is the low bits of the accepted frame, only while locked
    a_r9_payload: assert property (@(posedge clk) disable iff (rst)
        dsd_valid |-> (mode_dsd && dsd_left == $past(in_left[PAYLOAD_W-1:0])
                       && dsd_right == $past(in_right[PAYLOAD_W-1:0])));

    // R8: PCM output is the unchanged frame
    a_r8_pass: assert property (@(posedge clk) disable iff (rst)
        pcm_valid |-> (pcm_left == $past(in_left) && pcm_right == $past(in_right)));

    // R10: no frame in, no strobe out
    a_r10_idle: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!pcm_valid && !dsd_valid));
endmodule

// File: tb/dop_detect_tb.sv
module dop_detect_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        det_enable;
    logic [7:0]  run_threshold;
    logic        in_valid;
    logic [23:0] in_left;
    logic [23:0] in_right;
    logic        mode_dsd;
    logic        pcm_valid;
    logic [23:0] pcm_left;
    logic [23:0] pcm_right;
    logic        dsd_valid;
    logic [15:0] dsd_left;
    logic [15:0] dsd_right;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    dop_detect dut_i (
        .clk(clk), .rst(rst), .det_enable(det_enable), .run_threshold(run_threshold),
        .in_valid(in_valid), .in_left(in_left), .in_right(in_right),
        .mode_dsd(mode_dsd), .pcm_valid(pcm_valid), .pcm_left(pcm_left),
        .pcm_right(pcm_right), .dsd_valid(dsd_valid), .dsd_left(dsd_left),
        .dsd_right(dsd_right)
    );

    task automatic chk(input bit ok, input string req, input logic [47:0] act, input logic [47:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one frame; checks the registered output one cycle later
    task automatic send(input logic [7:0] ml, input logic [7:0] mr, input logic [15:0] p,
                        input bit exp_dsd, input bit exp_mode, input string req);
        logic [23:0] l;
        logic [23:0] r;
        l = {ml, p};
        r = {mr, ~p};
        @(negedge clk);
        in_valid = 1'b1; in_left = l; in_right = r;
        @(negedge clk);
        in_valid = 1'b0;
        chk(mode_dsd == exp_mode, {req, " mode"}, 48'(mode_dsd), 48'(exp_mode));
        if (exp_dsd) begin
            chk(dsd_valid && !pcm_valid && dsd_left == p && dsd_right == ~p,
                {req, " R9 dsd out"}, {pcm_valid, dsd_valid, dsd_left, dsd_right},
                {1'b0, 1'b1, p, ~p});
        end else begin
            chk(pcm_valid && !dsd_valid && pcm_left == l && pcm_right == r,
                {req, " R8 pcm out"}, {pcm_left, pcm_right}, {l, r});
        end
    endtask

    function automatic logic [7:0] alt(input int i);
        return (i % 2 == 0) ? 8'h05 : 8'hFA;
    endfunction

    // run of n alternating frames from an empty run; lock after thr+1
    task automatic fresh_lock(input int n, input int thr, input string req);
        for (int i = 0; i < n; i++) begin
            send(alt(i), alt(i), 16'hA5C3 ^ 16'(i), i > thr, i >= thr, req);
        end
    endtask

    task automatic t_reset;
        rst = 1'b1; det_enable = 1'b0; run_threshold = 8'd3;
        in_valid = 1'b0; in_left = '0; in_right = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!mode_dsd && !pcm_valid && !dsd_valid, "R1 reset state",
            48'({mode_dsd, pcm_valid, dsd_valid}), 48'(0));
    endtask

    task automatic t_lock;
        det_enable = 1'b1;
        @(negedge clk);
        fresh_lock(6, 3, "R2 R3 lock");
    endtask

    task automatic t_idle;
        repeat (3) begin
            @(negedge clk);
            chk(!pcm_valid && !dsd_valid && mode_dsd, "R10 idle",
                48'({mode_dsd, pcm_valid, dsd_valid}), 48'(3'b100));
        end
        send(8'h05, 8'h05, 16'h1234, 1'b1, 1'b1, "R10 run kept");
    endtask

    task automatic t_bad_marker;
        send(8'h12, 8'h12, 16'hBEEF, 1'b0, 1'b0, "R5 bad marker");
        fresh_lock(5, 3, "R6 relock after malformed");
    endtask

    task automatic t_repeat;
        // last frame was 0x05; repeating it is well-formed but out of order
        send(8'h05, 8'h05, 16'h0F0F, 1'b0, 1'b0, "R6 repeat");
        send(8'hFA, 8'hFA, 16'h0001, 1'b0, 1'b0, "R6 run2");
        send(8'h05, 8'h05, 16'h0002, 1'b0, 1'b0, "R6 run3");
        send(8'hFA, 8'hFA, 16'h0003, 1'b0, 1'b1, "R6 run4 lock");
        send(8'h05, 8'h05, 16'h8000, 1'b1, 1'b1, "R6 R9 msb first");
    endtask

    task automatic t_mismatch;
        send(8'hFA, 8'h05, 16'h5555, 1'b0, 1'b0, "R2 channel mismatch");
        fresh_lock(4, 3, "R2 relock after mismatch");
    endtask

    task automatic t_disable;
        @(negedge clk);
        det_enable = 1'b0;
        @(negedge clk);
        chk(!mode_dsd, "R7 mode off", 48'(mode_dsd), 48'(0));
        for (int i = 0; i < 6; i++) send(alt(i), alt(i), 16'(i), 1'b0, 1'b0, "R7 disabled");
        det_enable = 1'b1;
        fresh_lock(5, 3, "R7 full run after enable");
    endtask

    task automatic t_thr0;
        run_threshold = 8'd0;
        send(8'h33, 8'h33, 16'h0, 1'b0, 1'b0, "R4 thr0 break");
        send(8'hFA, 8'hFA, 16'h7777, 1'b0, 1'b1, "R3 thr0 first");
        send(8'h05, 8'h05, 16'h8888, 1'b1, 1'b1, "R3 thr0 second");
    endtask

    task automatic t_sat;
        run_threshold = 8'd255;
        send(8'h00, 8'h00, 16'h0, 1'b0, 1'b0, "R4 sat break");
        fresh_lock(300, 255, "R4 long run");
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_lock();
        t_idle();
        t_bad_marker();
        t_repeat();
        t_mismatch();
        t_disable();
        t_thr0();
        t_sat();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule